// File: doc/BRIEF.md
# CEC Transmit Frame Stager

This block holds a single outgoing CEC frame that a host loads through a small register window. It feeds the frame byte by byte to a bit-level CEC line transmitter and resends the whole frame when an attempt fails. A frame is the header byte (initiator and destination logical addresses), then an opcode, then up to `N_OPND` operands. A header-only poll frame is chosen with a flag in the destination register.

The host sets a retry limit, fills the frame registers and starts the frame with one write that also gives the operand count. While the frame is in flight, the host window is frozen except for a buffer-clear request. When the frame ends, the block raises an empty event. If the frame failed, it also raises one of two error events and keeps a sticky status code, and the host can read back how many retransmissions were made. Line timing and bus-idle measurement belong to the line transmitter.

Top module: `cec_tx_stager`

## Requirements
- R1: The first byte of every attempt is the header: initiator register bits 3:0 in the upper nibble and destination register bits 3:0 in the lower nibble.
- R2: When destination register bit 7 is set, the frame is a poll. Only the header is sent, and `xb_eom` is set on the header.
- R3: A non-poll frame sends the header, then the opcode, then operands 0..n-1 in order. Operand i is written at byte address 0x40+4*i. `xb_eom` marks the last byte. An operand count above `N_OPND` (14) is clamped to `N_OPND`.
- R4: A write to the start register (0x10) with bit 4 set starts a frame when the block is idle, and bits 3:0 of that write give the operand count. The same write with bit 4 clear only stores the count. Start register reads return the count in bits 3:0 and the busy flag in bit 4.
- R5: A byte answered with a negative acknowledge or a lost arbitration counts as one failed attempt. Unless that attempt was the last one allowed, the frame restarts from the header. Control register (0x00) bits 6:4 set the retry limit, which is the number of allowed attempts minus one.
- R6: When the last allowed attempt ends in a negative acknowledge, `ev_empty` and `ev_nack_max` pulse for one cycle and status register (0x14) reads 2. Control bits 6:4 then read the number of retransmissions made, which equals the limit.
- R7: When the last allowed attempt ends in a lost arbitration, `ev_empty` and `ev_arb_lost` pulse and the status register reads 1.
- R8: A frame that completes pulses `ev_empty` alone and leaves the status register at 0.
- R9: Register writes made while a frame is in flight have no effect: later bytes, retries and read-backs still show the earlier values.
- R10: Writing 1 to control bit 7 requests a buffer clear, and the bit reads 1 until the clear is done. When the block is idle, the clear finishes one cycle later and zeroes the frame registers and the count. When a frame is in flight, it ends after the byte now on the line, with no event raised.
- R11: After reset, no byte is offered and the control, start and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational from `host_addr`) |
| xb_valid | output | 1 | A frame byte is offered to the line transmitter |
| xb_data | output | 8 | Offered byte |
| xb_eom | output | 1 | Offered byte is the last of the frame |
| xb_done | input | 1 | Line transmitter finished the offered byte |
| xb_nack | input | 1 | With `xb_done`: the byte was not acknowledged |
| xb_arb_lost | input | 1 | With `xb_done`: arbitration was lost |
| ev_empty | output | 1 | One-cycle pulse: the frame has ended (success or failure) |
| ev_nack_max | output | 1 | One-cycle pulse: retries used up on negative acknowledge |
| ev_arb_lost | output | 1 | One-cycle pulse: retries used up on lost arbitration |

## Verification
The first byte is offered in the cycle right after the clock edge that takes the start write. Each following byte, or a restart at the header, is offered one cycle after the edge that takes `xb_done`. The events pulse in the cycle after the edge that takes the final `xb_done`. An idle buffer clear is visible on the control register for exactly one cycle. The bench acts as the line transmitter: at each falling edge it compares the offered byte against a queue of expected bytes and answers with the scripted response. It counts events at every falling edge and reads registers combinationally right after write edges, so a result one cycle late or early shows up as a mismatch.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
    localparam logic [7:0] A_CTL   = 8'h00;
    localparam logic [7:0] A_INIT  = 8'h04;
    localparam logic [7:0] A_DEST  = 8'h08;
    localparam logic [7:0] A_OPC   = 8'h0C;
    localparam logic [7:0] A_START = 8'h10;
    localparam logic [7:0] A_STAT  = 8'h14;
    localparam logic [7:0] A_OPND  = 8'h40;

    localparam logic [1:0] ST_OK   = 2'b00;
    localparam logic [1:0] ST_ARB  = 2'b01;
    localparam logic [1:0] ST_NACK = 2'b10;

    typedef enum logic [0:0] {SQ_IDLE, SQ_SEND} sq_state_e;
endpackage

// File: rtl/cec_tx_regs.sv
module cec_tx_regs
    import cec_tx_pkg::*;
#(
    parameter int unsigned N_OPND = 14,
    localparam int unsigned CW = $clog2(N_OPND + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_we,
    input  logic [7:0]              host_addr,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    input  logic                    busy,
    input  logic                    wipe,
    input  logic [2:0]              att,
    input  logic [1:0]              stat,
    input  logic                    clr_pend,
    output logic                    start,
    output logic                    clear_wr,
    output logic [7:0]              hdr,
    output logic                    poll,
    output logic [7:0]              opc,
    output logic [N_OPND-1:0][7:0]  opnd,
    output logic [CW-1:0]           cnt,
    output logic [2:0]              limit
);
    typedef struct packed {
        logic [3:0]             init;
        logic [3:0]             dest;
        logic                   poll;
        logic [7:0]             opc;
        logic [N_OPND-1:0][7:0] opnd;
        logic [CW-1:0]          cnt;
        logic [2:0]             limit;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d        = q;
        start    = 1'b0;
        clear_wr = 1'b0;
        if (host_we) begin
            if (host_addr == A_CTL && host_wdata[7]) clear_wr = 1'b1;
            if (!busy) begin
                if (host_addr == A_CTL)  d.limit = host_wdata[6:4];
                if (host_addr == A_INIT) d.init  = host_wdata[3:0];
                if (host_addr == A_DEST) begin
                    d.poll = host_wdata[7];
                    d.dest = host_wdata[3:0];
                end
                if (host_addr == A_OPC)  d.opc = host_wdata;
                if (host_addr == A_START) begin
                    d.cnt = (32'(host_wdata[3:0]) > N_OPND) ? CW'(N_OPND)
                                                            : CW'(host_wdata[3:0]);
                    start = host_wdata[4];
                end
                for (int i = 0; i < N_OPND; i++) begin
                    if (host_addr == A_OPND + 8'(4 * i)) d.opnd[i] = host_wdata;
                end
            end
        end
        if (wipe) begin
            d.init = '0;
            d.dest = '0;
            d.poll = 1'b0;
            d.opc  = '0;
            d.opnd = '0;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == A_CTL)
            host_rdata = {clr_pend, (busy || stat != ST_OK) ? att : q.limit, 4'b0000};
        if (host_addr == A_INIT) host_rdata = {4'b0000, q.init};
        if (host_addr == A_DEST) host_rdata = {q.poll, 3'b000, q.dest};
        if (host_addr == A_OPC)  host_rdata = q.opc;
        if (host_addr == A_START) begin
            host_rdata[4]      = busy;
            host_rdata[CW-1:0] = q.cnt;
        end
        if (host_addr == A_STAT) host_rdata = {6'b000000, stat};
        for (int i = 0; i < N_OPND; i++) begin
            if (host_addr == A_OPND + 8'(4 * i)) host_rdata = q.opnd[i];
        end
    end

    assign hdr   = {q.init, q.dest};
    assign poll  = q.poll;
    assign opc   = q.opc;
    assign opnd  = q.opnd;
    assign cnt   = q.cnt;
    assign limit = q.limit;

    AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(q.limit) && $stable(q.opc) && $stable(q.cnt)); // R9
    AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wipe && !host_we |=> q.cnt == '0 && q.opc == '0); // R10
endmodule

// File: rtl/cec_tx_seq.sv
module cec_tx_seq
    import cec_tx_pkg::*;
#(
    parameter int unsigned N_OPND = 14,
    localparam int unsigned CW = $clog2(N_OPND + 1),
    localparam int unsigned IW = $clog2(N_OPND + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   clear_wr,
    input  logic [7:0]             hdr,
    input  logic                   poll,
    input  logic [7:0]             opc,
    input  logic [N_OPND-1:0][7:0] opnd,
    input  logic [CW-1:0]          cnt,
    input  logic [2:0]             limit,
    input  logic                   xb_done,
    input  logic                   xb_nack,
    input  logic                   xb_arb_lost,
    output logic                   xb_valid,
    output logic [7:0]             xb_data,
    output logic                   xb_eom,
    output logic                   busy,
    output logic                   wipe,
    output logic [2:0]             att,
    output logic [1:0]             stat,
    output logic                   clr_pend,
    output logic                   ev_empty,
    output logic                   ev_nack_max,
    output logic                   ev_arb_lost
);
    typedef struct packed {
        sq_state_e     st;
        logic [IW-1:0] idx;
        logic [2:0]    att;
        logic [1:0]    stat;
        logic          clr;
        logic          ev_e;
        logic          ev_n;
        logic          ev_a;
    } seq_t;

    seq_t q, d;
    logic [IW:0] total;
    logic        last;
    logic        fail;

    assign total = poll ? (IW+1)'(1) : (IW+1)'(cnt) + (IW+1)'(2);
    assign last  = ((IW+1)'(q.idx) + (IW+1)'(1)) == total;
    assign fail  = xb_nack || xb_arb_lost;

    always_comb begin
        xb_data = hdr;
        if (q.idx == IW'(1)) xb_data = opc;
        for (int i = 0; i < N_OPND; i++) begin
            if (q.idx == IW'(i + 2)) xb_data = opnd[i];
        end
    end

    always_comb begin
        d      = q;
        d.ev_e = 1'b0;
        d.ev_n = 1'b0;
        d.ev_a = 1'b0;
        wipe   = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (q.clr) begin
                    wipe   = 1'b1;
                    d.clr  = 1'b0;
                    d.stat = ST_OK;
                    d.att  = '0;
                end else if (start) begin
                    d.st   = SQ_SEND;
                    d.idx  = '0;
                    d.att  = '0;
                    d.stat = ST_OK;
                end
            end
            SQ_SEND: begin
                if (xb_done) begin
                    if (q.clr) begin
                        d.st = SQ_IDLE;
                    end else if (fail) begin
                        if (q.att == limit) begin
                            d.st   = SQ_IDLE;
                            d.ev_e = 1'b1;
                            d.ev_a = xb_arb_lost;
                            d.ev_n = !xb_arb_lost;
                            d.stat = xb_arb_lost ? ST_ARB : ST_NACK;
                        end else begin
                            d.att = q.att + 3'd1;
                            d.idx = '0;
                        end
                    end else if (last) begin
                        d.st   = SQ_IDLE;
                        d.ev_e = 1'b1;
                    end else begin
                        d.idx = q.idx + IW'(1);
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
        if (clear_wr) d.clr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign xb_valid    = (q.st == SQ_SEND);
    assign xb_eom      = xb_valid && last;
    assign busy        = xb_valid;
    assign att         = q.att;
    assign stat        = q.stat;
    assign clr_pend    = q.clr;
    assign ev_empty    = q.ev_e;
    assign ev_nack_max = q.ev_n;
    assign ev_arb_lost = q.ev_a;

    AST_POLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid && poll && q.idx == '0 |-> xb_eom); // R2
    AST_RESTART_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid && xb_done && fail && !q.clr && q.att != limit |=> xb_valid && q.idx == '0); // R5
    AST_ATT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> q.att <= limit); // R5
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid && xb_done && xb_eom && !fail && !q.clr |=> !xb_valid && ev_empty && !ev_nack_max && !ev_arb_lost); // R8
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_nack_max, ev_arb_lost})); // R7
    AST_ERR_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack_max |-> ev_empty); // R6
    AST_CLR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        q.clr && xb_valid && xb_done |=> !xb_valid && !ev_empty); // R10
endmodule

// File: rtl/cec_tx_stager.sv
module cec_tx_stager
    import cec_tx_pkg::*;
#(
    parameter int unsigned N_OPND = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       xb_valid,
    output logic [7:0] xb_data,
    output logic       xb_eom,
    input  logic       xb_done,
    input  logic       xb_nack,
    input  logic       xb_arb_lost,
    output logic       ev_empty,
    output logic       ev_nack_max,
    output logic       ev_arb_lost
);
    localparam int unsigned CW = $clog2(N_OPND + 1);

    logic                   busy, wipe, clr_pend, start, clear_wr, poll;
    logic [2:0]             att, limit;
    logic [1:0]             stat;
    logic [7:0]             hdr, opc;
    logic [N_OPND-1:0][7:0] opnd;
    logic [CW-1:0]          cnt;

    cec_tx_regs #(.N_OPND(N_OPND)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .wipe       (wipe),
        .att        (att),
        .stat       (stat),
        .clr_pend   (clr_pend),
        .start      (start),
        .clear_wr   (clear_wr),
        .hdr        (hdr),
        .poll       (poll),
        .opc        (opc),
        .opnd       (opnd),
        .cnt        (cnt),
        .limit      (limit)
    );

    cec_tx_seq #(.N_OPND(N_OPND)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .clear_wr    (clear_wr),
        .hdr         (hdr),
        .poll        (poll),
        .opc         (opc),
        .opnd        (opnd),
        .cnt         (cnt),
        .limit       (limit),
        .xb_done     (xb_done),
        .xb_nack     (xb_nack),
        .xb_arb_lost (xb_arb_lost),
        .xb_valid    (xb_valid),
        .xb_data     (xb_data),
        .xb_eom      (xb_eom),
        .busy        (busy),
        .wipe        (wipe),
        .att         (att),
        .stat        (stat),
        .clr_pend    (clr_pend),
        .ev_empty    (ev_empty),
        .ev_nack_max (ev_nack_max),
        .ev_arb_lost (ev_arb_lost)
    );

    AST_NO_EVENT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid |-> !ev_empty); // R8
endmodule

// File: tb/tb_cec_tx_stager.sv
`timescale 1ns/1ps
module tb_cec_tx_stager;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       xb_valid, xb_eom;
    logic [7:0] xb_data;
    logic       xb_done = 1'b0, xb_nack = 1'b0, xb_arb_lost = 1'b0;
    logic       ev_empty, ev_nack_max, ev_arb_lost;

    always #2.5 clk = ~clk;

    cec_tx_stager dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .xb_valid(xb_valid),
        .xb_data(xb_data), .xb_eom(xb_eom), .xb_done(xb_done), .xb_nack(xb_nack),
        .xb_arb_lost(xb_arb_lost), .ev_empty(ev_empty), .ev_nack_max(ev_nack_max),
        .ev_arb_lost(ev_arb_lost)
    );

    typedef struct {
        logic [7:0] data;
        bit         eom;
        int         resp;   // 0 ack, 1 nack, 2 arbitration lost
        string      req;
    } item_t;

    item_t exp_q[$];
    item_t it;
    int checks = 0, errors = 0;
    int n_empty = 0, n_nack = 0, n_arb = 0;
    int cyc = 0;
    bit ended = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input bit eom, input int resp, input string req);
        item_t x;
        x.data = d; x.eom = eom; x.resp = resp; x.req = req;
        exp_q.push_back(x);
    endtask

    // line transmitter model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_empty)    n_empty++;
            if (ev_nack_max) n_nack++;
            if (ev_arb_lost) n_arb++;
            if (xb_done) begin
                xb_done = 1'b0; xb_nack = 1'b0; xb_arb_lost = 1'b0;
            end else if (xb_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4 unexpected byte actual=%0h expected=none", xb_data);
                    xb_done = 1'b1;
                end else begin
                    it = exp_q.pop_front();
                    chk(it.req, xb_data, it.data);
                    chk(it.req, xb_eom, it.eom);
                    xb_done = 1'b1;
                    xb_nack = (it.resp == 1);
                    xb_arb_lost = (it.resp == 2);
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic settle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic ev_check(input string req, input int e0, input int n0, input int a0,
                            input int de, input int dn, input int da);
        chk(req, n_empty - e0, de);
        chk(req, n_nack - n0, dn);
        chk(req, n_arb - a0, da);
    endtask

    initial begin
        logic [7:0] v;
        int e0, n0, a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", xb_valid, 0);
        rd(8'h00, v); chk("R11", v, 8'h00);
        rd(8'h10, v); chk("R11", v, 8'h00);
        rd(8'h14, v); chk("R11", v, 8'h00);

        // R1 R3 R8: plain frame, two operands
        wr(8'h00, 8'h20);
        wr(8'h04, 8'h04);
        wr(8'h08, 8'h00);
        wr(8'h0C, 8'h36);
        wr(8'h40, 8'hA1);
        wr(8'h44, 8'hB2);
        push(8'h40, 0, 0, "R1"); push(8'h36, 0, 0, "R3");
        push(8'hA1, 0, 0, "R3"); push(8'hB2, 1, 0, "R3");
        e0 = n_empty; n0 = n_nack; a0 = n_arb;
        wr(8'h10, 8'h12);
        settle();
        ev_check("R8", e0, n0, a0, 1, 0, 0);
        rd(8'h14, v); chk("R8", v, 8'h00);

        // R5 R6 R9: negative acknowledges until the limit, opcode write during frame
        push(8'h40, 0, 0, "R5"); push(8'h36, 0, 1, "R5");
        push(8'h40, 0, 1, "R5"); push(8'h40, 0, 1, "R5");
        e0 = n_empty; n0 = n_nack; a0 = n_arb;
        wr(8'h10, 8'h12);
        wr(8'h0C, 8'h99);
        settle();
        ev_check("R6", e0, n0, a0, 1, 1, 0);
        rd(8'h14, v); chk("R6", v, 8'h02);
        rd(8'h00, v); chk("R6", v, 8'h20);
        rd(8'h0C, v); chk("R9", v, 8'h36);

        // R2 poll frame
        wr(8'h08, 8'h85);
        rd(8'h08, v); chk("R2", v, 8'h85);
        push(8'h45, 1, 0, "R2");
        e0 = n_empty; n0 = n_nack; a0 = n_arb;
        wr(8'h10, 8'h10);
        settle();
        ev_check("R2", e0, n0, a0, 1, 0, 0);

        // R7 arbitration lost with limit 0
        wr(8'h00, 8'h00);
        wr(8'h08, 8'h05);
        push(8'h45, 0, 2, "R7");
        e0 = n_empty; n0 = n_nack; a0 = n_arb;
        wr(8'h10, 8'h10);
        settle();
        ev_check("R7", e0, n0, a0, 1, 0, 1);
        rd(8'h14, v); chk("R7", v, 8'h01);

        // R5: one lost arbitration then success with limit 1
        wr(8'h00, 8'h10);
        push(8'h45, 0, 2, "R5"); push(8'h45, 0, 0, "R5"); push(8'h36, 1, 0, "R5");
        e0 = n_empty; n0 = n_nack; a0 = n_arb;
        wr(8'h10, 8'h10);
        settle();
        ev_check("R5", e0, n0, a0, 1, 0, 0);
        rd(8'h14, v); chk("R5", v, 8'h00);

        // R4: count write without the start bit
        wr(8'h10, 8'h02);
        repeat (20) @(negedge clk);
        chk("R4", xb_valid, 0);
        rd(8'h10, v); chk("R4", v, 8'h02);

        // R3 clamp of operand count
        for (int i = 0; i < 14; i++) wr(8'h40 + 8'(4 * i), 8'h10 + 8'(i));
        push(8'h45, 0, 0, "R3"); push(8'h36, 0, 0, "R3");
        for (int i = 0; i < 14; i++) push(8'h10 + 8'(i), i == 13, 0, "R3");
        e0 = n_empty; n0 = n_nack; a0 = n_arb;
        wr(8'h10, 8'h1F);
        settle();
        ev_check("R3", e0, n0, a0, 1, 0, 0);
        rd(8'h10, v); chk("R3", v, 8'h0E);

        // R10 clear while idle
        wr(8'h00, 8'h80);
        rd(8'h00, v); chk("R10", v, 8'h80);
        @(negedge clk);
        rd(8'h00, v); chk("R10", v, 8'h00);
        rd(8'h0C, v); chk("R10", v, 8'h00);
        rd(8'h40, v); chk("R10", v, 8'h00);
        rd(8'h10, v); chk("R10", v, 8'h00);

        // R10 clear while busy: ends after the byte on the line
        wr(8'h04, 8'h03);
        wr(8'h08, 8'h0F);
        wr(8'h0C, 8'h44);
        wr(8'h40, 8'h55);
        wr(8'h44, 8'h66);
        push(8'h3F, 0, 0, "R10"); push(8'h44, 0, 0, "R10");
        e0 = n_empty; n0 = n_nack; a0 = n_arb;
        wr(8'h10, 8'h12);
        wr(8'h00, 8'h80);
        settle();
        repeat (20) @(negedge clk);
        chk("R10", xb_valid, 0);
        ev_check("R10", e0, n0, a0, 0, 0, 0);
        rd(8'h00, v); chk("R10", v, 8'h00);
        rd(8'h0C, v); chk("R10", v, 8'h00);

        finish_run();
    end
endmodule